// File: doc/BRIEF.md
# Transaction ID Allocator for an AXI Master Port

This block sits between a processor's memory request sources and its AXI master port. For every read or write address request it picks the 4-bit transaction ID from the request class and the memory attribute of the access. Every ID is chosen separately for the read and write address channels. Accesses that allocate into or leave the level-2 cache draw from a shared pool of four IDs. Each pooled ID stands for exactly one outstanding linefill or eviction. A pooled ID returns to the pool when its read-last beat or write response comes back.

The block counts outstanding reads and writes. It holds back a request that would break the read cap, the write cap, the combined cap, or the limit of four pooled transactions. Grant, stall and ID are combinational from the current request and the completions of the same cycle. A stalled requester keeps its request up until it is granted, so nothing is lost. The counters and the pool state change on the next rising clock edge.

Top module: `axi_id_alloc`

## Requirements
- R1: Read IDs for requests that are not L2-cacheable. Attribute codes: 0 = L2-cacheable, 1 = L1-only cacheable, 2 = non-cacheable / strongly ordered / write-through, 3 = shared device, 4 = non-shared device, 5 = cacheable non-burst, 6-7 = treated as 2. Read class codes: 0 = instruction fetch, 1 = integer load, 2 = SIMD/FP load (also 5-7), 3 = table walk, 4 = preload. The IDs are:
  - Fetch: 4'b1111 for attribute 1, 4'b0101 for attributes 3 and 4, otherwise 4'b0100.
  - Integer load: 4'b1110 for attribute 1.
  - Integer and SIMD loads: 4'b0001 for attribute 3, 4'b0011 for attribute 4, otherwise 4'b0000.
  - Table walk: always 4'b0110.
- R2: Write IDs for requests that are not pooled. Write class codes: 0 = L2 eviction, 1 = integer store (also 5-7), 2 = SIMD/FP store, 3 = preload-for-write, 4 = cache maintenance. A store uses 4'b0010 for attribute 5, 4'b0001 for attribute 3, 4'b0011 for attribute 4, and 4'b0000 otherwise.
- R3: The following requests take a pooled ID in the range 4'b1000-4'b1011, lowest free first:
  - any request with attribute 0;
  - a read preload;
  - an eviction, a write preload, or a maintenance write.
- R4: A pooled ID is freed by a read-last completion (read side) or a write response (write side) carrying that ID. Afterwards it can be handed out again.
- R5: At most 18 reads are outstanding. A read beyond that stalls.
- R6: At most 12 writes are outstanding. A write beyond that stalls.
- R7: At most 26 transactions are outstanding across both channels.
- R8: At most four pooled transactions are outstanding. A pooled request with no free ID stalls.
- R9: The stall output equals valid and not grant, in the same cycle as the request. Grant and stall are never both high. A held request is granted once capacity frees.
- R10: A completion in the same cycle as a request frees its capacity or its pooled ID for that request.
- R11: Synchronous active-high reset clears all counts and frees all four pooled IDs. With no request, grant and stall are low.
- R12: A completion with no matching outstanding transaction changes no count and no pool state. Counters move by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request present |
| req_write | input | 1 | 1 = write channel, 0 = read channel |
| req_class | input | 3 | Request class code (R1/R2) |
| req_attr | input | 3 | Memory attribute code (R1) |
| req_grant | output | 1 | Request accepted this cycle |
| req_stall | output | 1 | Request held this cycle |
| req_id | output | 4 | Assigned transaction ID |
| rd_done_valid | input | 1 | Read-last beat seen |
| rd_done_id | input | 4 | ID of the completed read |
| wr_done_valid | input | 1 | Write response seen |
| wr_done_id | input | 4 | ID of the completed write |

## Verification
Grant, stall and ID are due in the same cycle the request is driven, with no register on the path. The bench therefore drives inputs just after a falling edge and samples a few nanoseconds later, before the next rising edge. Counter and pool effects show one cycle later, as the grant or ID of the following request. Each check samples at the falling-edge slot after the rising edge that commits the change. Same-cycle completions are driven in the same slot as the request they are meant to unblock.

// File: rtl/axi_id_pkg.sv
package axi_id_pkg;

  typedef enum logic [2:0] {
    RC_FETCH   = 3'd0,
    RC_ILOAD   = 3'd1,
    RC_VLOAD   = 3'd2,
    RC_WALK    = 3'd3,
    RC_PRELOAD = 3'd4
  } rd_class_e;

  typedef enum logic [2:0] {
    WC_EVICT   = 3'd0,
    WC_ISTORE  = 3'd1,
    WC_VSTORE  = 3'd2,
    WC_PRELOAD = 3'd3,
    WC_MAINT   = 3'd4
  } wr_class_e;

  typedef enum logic [2:0] {
    AT_L2C    = 3'd0,
    AT_L1ONLY = 3'd1,
    AT_NC     = 3'd2,
    AT_SHDEV  = 3'd3,
    AT_NSDEV  = 3'd4,
    AT_CNB    = 3'd5
  } attr_e;

  typedef struct packed {
    logic       pooled;
    logic [3:0] id;
  } id_pick_t;

  function automatic id_pick_t map_read(input logic [2:0] cls, input logic [2:0] attr);
    id_pick_t r;
    r.pooled = (attr == AT_L2C) || (cls == RC_PRELOAD);
    r.id     = 4'b0000;
    if (!r.pooled) begin
      case (cls)
        RC_FETCH: begin
          if (attr == AT_L1ONLY) r.id = 4'b1111;
          else if (attr == AT_SHDEV || attr == AT_NSDEV) r.id = 4'b0101;
          else r.id = 4'b0100;
        end
        RC_WALK: r.id = 4'b0110;
        RC_ILOAD: begin
          if (attr == AT_L1ONLY) r.id = 4'b1110;
          else if (attr == AT_SHDEV) r.id = 4'b0001;
          else if (attr == AT_NSDEV) r.id = 4'b0011;
          else r.id = 4'b0000;
        end
        default: begin
          if (attr == AT_SHDEV) r.id = 4'b0001;
          else if (attr == AT_NSDEV) r.id = 4'b0011;
          else r.id = 4'b0000;
        end
      endcase
    end
    return r;
  endfunction

  function automatic id_pick_t map_write(input logic [2:0] cls, input logic [2:0] attr);
    id_pick_t r;
    r.pooled = (attr == AT_L2C) || (cls == WC_EVICT) ||
               (cls == WC_PRELOAD) || (cls == WC_MAINT);
    r.id     = 4'b0000;
    if (!r.pooled) begin
      case (attr)
        AT_CNB:   r.id = 4'b0010;
        AT_SHDEV: r.id = 4'b0001;
        AT_NSDEV: r.id = 4'b0011;
        default:  r.id = 4'b0000;
      endcase
    end
    return r;
  endfunction

  // Count after an optional decrement that never goes below zero.
  function automatic int unsigned after_dec(input int unsigned cnt, input logic dec);
    return (dec && cnt != 0) ? cnt - 1 : cnt;
  endfunction

endpackage

// File: rtl/id_mapper.sv
module id_mapper
  import axi_id_pkg::*;
(
  input  logic       is_write,
  input  logic [2:0] cls,
  input  logic [2:0] attr,
  output logic       pooled,
  output logic [3:0] fixed_id
);
  id_pick_t pick;

  always_comb begin
    pick     = is_write ? map_write(cls, attr) : map_read(cls, attr);
    pooled   = pick.pooled;
    fixed_id = pick.id;
  end
endmodule

// File: rtl/txn_counter.sv
module txn_counter #(
  parameter int unsigned MAX = 18,
  localparam int unsigned W  = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_eff,
  output logic         room
);
  import axi_id_pkg::*;

  always_comb begin
    cnt_eff = W'(after_dec(int'(cnt), dec));
    room    = (int'(cnt_eff) < MAX);
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (inc && room)   cnt <= cnt_eff + W'(1);
    else                    cnt <= cnt_eff;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + W'(1)) || (cnt + W'(1) == $past(cnt))); // R12
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAX); // R12
endmodule

// File: rtl/id_pool.sv
module id_pool #(
  parameter int unsigned POOL_N    = 4,
  parameter logic [3:0]  POOL_BASE = 4'b1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic              rel_a_en,
  input  logic [3:0]        rel_a_id,
  input  logic              rel_b_en,
  input  logic [3:0]        rel_b_id,
  output logic              any_free,
  output logic [3:0]        alloc_id,
  output logic [POOL_N-1:0] busy
);
  logic [POOL_N-1:0] rel_mask;
  logic [POOL_N-1:0] free_eff;
  logic [POOL_N-1:0] pick_oh;

  for (genvar g = 0; g < POOL_N; g++) begin : g_slot
    localparam logic [3:0] SLOT_ID = POOL_BASE + 4'(g);
    assign rel_mask[g] = busy[g] &&
                         ((rel_a_en && rel_a_id == SLOT_ID) ||
                          (rel_b_en && rel_b_id == SLOT_ID));
  end

  always_comb begin
    free_eff = ~busy | rel_mask;
    pick_oh  = '0;
    alloc_id = POOL_BASE;
    for (int i = POOL_N - 1; i >= 0; i--) begin
      if (free_eff[i]) begin
        pick_oh  = '0;
        pick_oh[i] = 1'b1;
        alloc_id = POOL_BASE + 4'(i);
      end
    end
    any_free = |free_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~rel_mask) | (alloc_en ? pick_oh : '0);
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> any_free); // R8
  AST_ALLOC_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh)); // R3
  AST_POOL_SET: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> (busy != '0)); // R3
endmodule

// File: rtl/axi_id_alloc.sv
module axi_id_alloc #(
  parameter int unsigned RD_MAX  = 18,
  parameter int unsigned WR_MAX  = 12,
  parameter int unsigned TOT_MAX = 26,
  parameter int unsigned POOL_N  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [2:0] req_class,
  input  logic [2:0] req_attr,
  output logic       req_grant,
  output logic       req_stall,
  output logic [3:0] req_id,
  input  logic       rd_done_valid,
  input  logic [3:0] rd_done_id,
  input  logic       wr_done_valid,
  input  logic [3:0] wr_done_id
);
  localparam int unsigned RW = $clog2(RD_MAX + 1);
  localparam int unsigned WW = $clog2(WR_MAX + 1);
  localparam int unsigned TW = $clog2(RD_MAX + WR_MAX + 1);

  logic          pooled;
  logic [3:0]    fixed_id;
  logic [RW-1:0] rd_cnt, rd_eff;
  logic [WW-1:0] wr_cnt, wr_eff;
  logic          rd_room, wr_room;
  logic [TW-1:0] tot_eff;
  logic          tot_room;
  logic          pool_free;
  logic [3:0]    pool_id;
  logic [POOL_N-1:0] pool_busy;
  logic          grant_rd, grant_wr, alloc_en;

  id_mapper u_map (
    .is_write (req_write),
    .cls      (req_class),
    .attr     (req_attr),
    .pooled   (pooled),
    .fixed_id (fixed_id)
  );

  txn_counter #(.MAX(RD_MAX)) u_rd_cnt (
    .clk (clk), .rst (rst), .inc (grant_rd), .dec (rd_done_valid),
    .cnt (rd_cnt), .cnt_eff (rd_eff), .room (rd_room)
  );

  txn_counter #(.MAX(WR_MAX)) u_wr_cnt (
    .clk (clk), .rst (rst), .inc (grant_wr), .dec (wr_done_valid),
    .cnt (wr_cnt), .cnt_eff (wr_eff), .room (wr_room)
  );

  id_pool #(.POOL_N(POOL_N), .POOL_BASE(4'b1000)) u_pool (
    .clk      (clk),
    .rst      (rst),
    .alloc_en (alloc_en),
    .rel_a_en (rd_done_valid),
    .rel_a_id (rd_done_id),
    .rel_b_en (wr_done_valid),
    .rel_b_id (wr_done_id),
    .any_free (pool_free),
    .alloc_id (pool_id),
    .busy     (pool_busy)
  );

  always_comb begin
    tot_eff   = TW'(rd_eff) + TW'(wr_eff);
    tot_room  = (int'(tot_eff) < TOT_MAX);
    req_grant = req_valid && tot_room &&
                (req_write ? wr_room : rd_room) &&
                (!pooled || pool_free);
    req_stall = req_valid && !req_grant;
    req_id    = pooled ? pool_id : fixed_id;
    grant_rd  = req_grant && !req_write;
    grant_wr  = req_grant && req_write;
    alloc_en  = req_grant && pooled;
  end

  AST_RD_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(rd_cnt) <= RD_MAX); // R5
  AST_WR_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(wr_cnt) <= WR_MAX); // R6
  AST_TOT_CAP: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_cnt) + int'(wr_cnt)) <= TOT_MAX); // R7
  AST_POOL_CAP: assert property (@(posedge clk) disable iff (rst)
    $countones(pool_busy) <= POOL_N); // R8
  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(req_grant && req_stall)); // R9
  AST_POOL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_grant && pooled) |-> (req_id[3:2] == 2'b10)); // R3
  AST_RD_GROW: assert property (@(posedge clk) disable iff (rst)
    (grant_rd && !rd_done_valid) |=> (rd_cnt != '0)); // R5
endmodule

// File: tb/axi_id_alloc_bench.sv
`timescale 1ns/1ps
module axi_id_alloc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_class = 0, req_attr = 0;
  logic req_grant, req_stall;
  logic [3:0] req_id;
  logic rd_done_valid = 0, wr_done_valid = 0;
  logic [3:0] rd_done_id = 0, wr_done_id = 0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  axi_id_alloc u_axi_id_alloc (.*);

  // Expected ID for a request that is not pooled (R1, R2), restated per attribute.
  function automatic logic [3:0] exp_id(input logic w, input logic [2:0] c, input logic [2:0] a);
    if (w) return (a == 5) ? 4'h2 : (a == 3) ? 4'h1 : (a == 4) ? 4'h3 : 4'h0;
    if (c == 3) return 4'h6;
    if (a == 1) return (c == 0) ? 4'hF : (c == 1) ? 4'hE : 4'h0;
    if (a == 3) return (c == 0) ? 4'h5 : 4'h1;
    if (a == 4) return (c == 0) ? 4'h5 : 4'h3;
    return (c == 0) ? 4'h4 : 4'h0;
  endfunction

  task automatic cyc(input logic v, input logic w, input logic [2:0] c, input logic [2:0] a,
                     input logic rv, input logic [3:0] ri, input logic wv, input logic [3:0] wi);
    @(negedge clk);
    req_valid = v; req_write = w; req_class = c; req_attr = a;
    rd_done_valid = rv; rd_done_id = ri; wr_done_valid = wv; wr_done_id = wi;
    #4;
  endtask

  task automatic chk(input string tag, input logic eg, input logic [3:0] eid);
    tests++;
    if (req_grant !== eg || req_stall !== (req_valid && !eg) || (eg && req_id !== eid)) begin
      fails++;
      $display("FAIL %s: grant=%0b stall=%0b id=%h, expected grant=%0b id=%h",
               tag, req_grant, req_stall, req_id, eg, eid);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0; rd_done_valid = 0; wr_done_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic fill(input logic w, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1, w, 3'd1, 3'd2, 0, 0, 0, 0);
      chk(tag, 1, 4'h0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 idle after reset", 0, 0);
    cyc(1, 0, 3'd0, 3'd0, 0, 0, 0, 0);
    chk("R11 pool free after reset", 1, 4'h8);
  endtask

  task automatic t_read_map();
    do_reset();
    for (int c = 0; c < 4; c++)
      for (int a = 1; a <= 4; a++) begin
        cyc(1, 0, 3'(c), 3'(a), 0, 0, 0, 0);
        chk("R1 read mapping", 1, exp_id(0, 3'(c), 3'(a)));
      end
  endtask

  task automatic t_write_map();
    do_reset();
    for (int c = 1; c <= 2; c++)
      for (int a = 1; a <= 5; a++) begin
        cyc(1, 1, 3'(c), 3'(a), 0, 0, 0, 0);
        chk("R2 write mapping", 1, exp_id(1, 3'(c), 3'(a)));
      end
  endtask

  task automatic t_pool();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 3'd0, 3'd0, 0, 0, 0, 0);
      chk("R3 lowest free pooled id", 1, 4'(8 + i));
    end
    cyc(1, 0, 3'd1, 3'd0, 0, 0, 0, 0);
    chk("R8 pool exhausted stalls", 0, 0);
    cyc(1, 0, 3'd1, 3'd0, 0, 0, 0, 0);
    chk("R9 held request still stalled", 0, 0);
    cyc(1, 0, 3'd1, 3'd0, 1, 4'h9, 0, 0);
    chk("R10 same-cycle read-last frees id", 1, 4'h9);
    cyc(1, 1, 3'd0, 3'd2, 0, 0, 0, 0);
    chk("R8 eviction stalls on full pool", 0, 0);
    cyc(0, 0, 0, 0, 1, 4'h8, 0, 0);
    cyc(1, 1, 3'd0, 3'd2, 0, 0, 0, 0);
    chk("R4 freed id reused by eviction", 1, 4'h8);
    cyc(0, 0, 0, 0, 0, 0, 1, 4'h8);
    cyc(1, 0, 3'd4, 3'd2, 0, 0, 0, 0);
    chk("R4 write response frees id for preload", 1, 4'h8);
  endtask

  task automatic t_rd_cap();
    do_reset();
    fill(0, 18, "R5 reads under cap");
    cyc(1, 0, 3'd1, 3'd2, 0, 0, 0, 0);
    chk("R5 19th read stalls", 0, 0);
    cyc(1, 0, 3'd1, 3'd2, 1, 4'h0, 0, 0);
    chk("R10 same-cycle completion grants read", 1, 4'h0);
  endtask

  task automatic t_wr_cap();
    do_reset();
    fill(1, 12, "R6 writes under cap");
    cyc(1, 1, 3'd1, 3'd2, 0, 0, 0, 0);
    chk("R6 13th write stalls", 0, 0);
  endtask

  task automatic t_total();
    do_reset();
    fill(0, 18, "R7 reads");
    fill(1, 8, "R7 writes");
    cyc(1, 1, 3'd1, 3'd2, 0, 0, 0, 0);
    chk("R7 combined cap stalls write", 0, 0);
    cyc(1, 1, 3'd1, 3'd2, 1, 4'h0, 0, 0);
    chk("R7 read completion frees combined slot", 1, 4'h0);
  endtask

  task automatic t_underflow();
    do_reset();
    cyc(0, 0, 0, 0, 1, 4'h8, 1, 4'h9);
    cyc(0, 0, 0, 0, 1, 4'h0, 1, 4'h0);
    cyc(1, 0, 3'd0, 3'd0, 0, 0, 0, 0);
    chk("R12 stray completion leaves pool", 1, 4'h8);
    fill(0, 17, "R12 read count intact");
    cyc(1, 0, 3'd1, 3'd2, 0, 0, 0, 0);
    chk("R12 read count not wrapped", 0, 0);
    cyc(1, 1, 3'd1, 3'd2, 0, 0, 0, 0);
    chk("R12 write count not wrapped", 1, 4'h0);
  endtask

  initial begin
    t_reset();
    t_read_map();
    t_write_map();
    t_pool();
    t_rd_cap();
    t_wr_cap();
    t_total();
    t_underflow();
    @(negedge clk);
    req_valid = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule